// File: doc/BRIEF.md
# SAR Converter Controller with Parallel Read Port

This block is the digital half of a 12-bit successive-approximation converter. Two asynchronous active-low strobes, a chip select and a combined read/convert line, are brought into the clock domain. Their combination starts a conversion. A binary search then runs from the most significant bit down, one bit per fixed number of clock cycles. On each step it presents a trial code to the analog DAC and reads back a single comparator bit. An active-low busy flag covers the whole search.

The finished code is stored in a result register in two's complement form. It is shown on a 16-bit parallel port made of two 8-bit lanes, whose arrangement a lane-select input chooses. When the read conditions are not met, the port reports itself as released: its enable is low and all data lines are zero. A second convert command during a conversion aborts it and leaves the stored result untouched. While a conversion runs, the stored result can still be read for a bounded number of cycles. After that the port returns a fixed poison code until busy clears.

Top module: `sarc_top`

## Requirements
- R1: During and after reset, busy_n is high, dq_oe is low, dq and dac_code are zero, and the stored result is 000.
- R2: A conversion starts when sel_n and rdconv are both low, whichever of the two fell last. busy_n goes low on the third rising clock edge after both are low. Toggling rdconv while sel_n is high starts nothing.
- R3: The search tests bits from bit 11 down to bit 0, STEP_CYC cycles per bit. dac_code carries the offset-binary trial, with the tested bit set. A high cmp_in at the end of a step keeps that bit and a low one clears it. busy_n stays low for 12*STEP_CYC cycles and dac_code is zero while idle.
- R4: The stored result is the offset-binary search outcome with bit 11 inverted. An input at the top of the range reads 7FF, midscale reads 000, one step below midscale reads FFF, and the bottom of the range reads 800.
- R5: A new start condition while busy_n is low ends the conversion: busy_n is high one cycle later, dac_code is zero, and the stored result is unchanged. Holding the strobes low afterwards does not restart.
- R6: dq_oe is high exactly when the synchronised sel_n is low and rdconv is high, two cycles after the inputs. When dq_oe is low, dq is all zeros.
- R7: With lane_sel low, dq[15:4] holds the full word and dq[3:0] is zero. With lane_sel high, dq[15:8] holds {result[3:0],0000} and dq[7:0] holds result[11:4].
- R8: During a conversion the port shows the previous result for the first VALID_WIN cycles after the start edge. From then until busy_n rises it shows POISON (default BAD).
- R9: The stored result changes only on the edge where busy_n returns high. The new value is readable in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Active-low chip select, asynchronous |
| rdconv | input | 1 | Read (high) / convert (low) strobe, asynchronous |
| lane_sel | input | 1 | Byte-lane arrangement of the port |
| cmp_in | input | 1 | Comparator decision for the current trial, high when the input is at or above it |
| dac_code | output | 12 | Offset-binary trial code to the capacitor DAC |
| busy_n | output | 1 | Low while a conversion runs |
| dq | output | 16 | Parallel data, two 8-bit lanes |
| dq_oe | output | 1 | Port driven when high, released when low |

## Verification
The assertions assume that each strobe level is held for at least one full clock period, so that the two-stage synchroniser sees every edge. They also assume that cmp_in is a synchronous function of dac_code that is settled by the end of each step. The stimulus changes strobes only on falling clock edges and holds each level for several cycles. The comparator is modelled as the comparison of a fixed offset-binary input against dac_code, and that input never changes inside a conversion.

// File: rtl/sarc_pkg.sv
`timescale 1ns/1ps
package sarc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sarc_state_e;
endpackage

// File: rtl/sarc_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a vector of asynchronous levels.
module sarc_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sarc_seq.sv
`timescale 1ns/1ps
// Start/abort decode and successive-approximation search.
module sarc_seq
  import sarc_pkg::*;
#(
  parameter int DW       = 12,
  parameter int STEP_CYC = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cvt_req,
  input  logic          cmp_in,
  output logic          busy,
  output logic          start,
  output logic          res_we,
  output logic [DW-1:0] res_ob,
  output logic [DW-1:0] dac_code
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STEP_CYC - 1);
  localparam logic [IW-1:0] BIT_TOP  = IW'(DW - 1);
  localparam logic [DW-1:0] MSB_ONLY = {1'b1, {(DW-1){1'b0}}};

  sarc_state_e     st_q, st_d;
  logic            req_q;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [IW-1:0]   bidx_q, bidx_d;
  logic [DW-1:0]   trial_q, trial_d;
  logic [DW-1:0]   mask, decided;
  logic            step_en;

  assign start   = cvt_req & ~req_q;
  assign busy    = (st_q == ST_CONV);
  assign mask    = DW'(1) << bidx_q;
  assign decided = cmp_in ? trial_q : (trial_q & ~mask);
  assign step_en = busy | start;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    bidx_d  = bidx_q;
    trial_d = trial_q;
    res_we  = 1'b0;
    res_ob  = decided;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_CONV;
          cnt_d   = '0;
          bidx_d  = BIT_TOP;
          trial_d = MSB_ONLY;
        end
      end
      ST_CONV: begin
        if (start) begin
          st_d    = ST_IDLE;
          cnt_d   = '0;
          trial_d = '0;
        end else if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          if (bidx_q == '0) begin
            st_d    = ST_IDLE;
            trial_d = '0;
            res_we  = 1'b1;
          end else begin
            bidx_d  = bidx_q - 1'b1;
            trial_d = decided | (mask >> 1);
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      req_q   <= 1'b0;
      cnt_q   <= '0;
      bidx_q  <= '0;
      trial_q <= '0;
    end else begin
      req_q <= cvt_req;
      st_q  <= st_d;
      if (step_en) begin
        cnt_q   <= cnt_d;
        bidx_q  <= bidx_d;
        trial_q <= trial_d;
      end
    end
  end

  assign dac_code = trial_q;

  // R2: a start edge while idle begins a conversion
  a_r2_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cvt_req && !req_q) |=> busy);

  // R5: a start edge during a conversion aborts it
  a_r5_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cvt_req && !req_q) |=> (!busy && dac_code == '0));

  // R3: the first trial has only the top bit set
  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dac_code == MSB_ONLY));

  // R3: the trial holds for the whole step
  a_r3_trial_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && cnt_q != CNT_LAST) |=> $stable(dac_code));
endmodule

// File: rtl/sarc_bus.sv
`timescale 1ns/1ps
// Result register, stale-read window and byte-lane port.
module sarc_bus #(
  parameter int            DW        = 12,
  parameter int            LANE_W    = 8,
  parameter int            VALID_WIN = 300,
  parameter logic [DW-1:0] POISON    = 12'hBAD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                busy,
  input  logic                res_we,
  input  logic [DW-1:0]       res_ob,
  input  logic                sel_s,
  input  logic                rd_s,
  input  logic                lane_s,
  output logic [2*LANE_W-1:0] dq,
  output logic                dq_oe
);
  localparam int LO_W = DW - LANE_W;
  localparam int PAD  = LANE_W - LO_W;
  localparam int WCW  = (VALID_WIN > 0) ? $clog2(VALID_WIN + 1) : 1;
  localparam logic [WCW-1:0] WIN_MAX = WCW'(VALID_WIN);

  logic [DW-1:0]     res_q, res_d;
  logic [WCW-1:0]    win_q, win_d;
  logic              win_en, stale;
  logic [DW-1:0]     rd_val;
  logic [LANE_W-1:0] hi_lane, lo_lane;

  assign res_d  = {~res_ob[DW-1], res_ob[DW-2:0]};
  assign win_en = (start & ~busy) | busy;

  always_comb begin
    win_d = win_q;
    if (start && !busy)                win_d = '0;
    else if (busy && win_q != WIN_MAX) win_d = win_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      win_q <= '0;
    end else begin
      if (res_we) res_q <= res_d;
      if (win_en) win_q <= win_d;
    end
  end

  assign stale   = busy && (win_q == WIN_MAX);
  assign rd_val  = stale ? POISON : res_q;
  assign hi_lane = rd_val[DW-1 -: LANE_W];

  if (PAD > 0) begin : g_pad
    assign lo_lane = {rd_val[LO_W-1:0], {PAD{1'b0}}};
  end else begin : g_nopad
    assign lo_lane = rd_val[LO_W-1:0];
  end

  assign dq_oe = ~sel_s & rd_s;
  assign dq    = !dq_oe ? '0 : (lane_s ? {lo_lane, hi_lane} : {hi_lane, lo_lane});

  // R9: the result only moves on a completion strobe
  a_r9_res_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> $past(res_we));

  // R8: the window count restarts with each conversion
  a_r8_win_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (win_q == '0));

  // R7: unused low positions of the full-word layout are zero
  if (PAD > 0) begin : g_pad_chk
    a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && !lane_s) |-> (dq[PAD-1:0] == '0));
  end
endmodule

// File: rtl/sarc_top.sv
`timescale 1ns/1ps
module sarc_top #(
  parameter int            DW        = 12,
  parameter int            LANE_W    = 8,
  parameter int            STEP_CYC  = 36,
  parameter int            VALID_WIN = 300,
  parameter logic [DW-1:0] POISON    = 12'hBAD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n,
  input  logic                rdconv,
  input  logic                lane_sel,
  input  logic                cmp_in,
  output logic [DW-1:0]       dac_code,
  output logic                busy_n,
  output logic [2*LANE_W-1:0] dq,
  output logic                dq_oe
);
  logic          rst_ni;
  logic [2:0]    strb_s;
  logic          sel_s, rd_s, lane_s, cvt_req;
  logic          busy, start, res_we;
  logic [DW-1:0] res_ob;

  sarc_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ni)
  );

  sarc_sync #(.W(3), .STAGES(2), .RST_VAL(3'b011)) u_strb (
    .clk(clk), .rst_n(rst_ni), .d({lane_sel, rdconv, sel_n}), .q(strb_s)
  );

  assign sel_s   = strb_s[0];
  assign rd_s    = strb_s[1];
  assign lane_s  = strb_s[2];
  assign cvt_req = ~sel_s & ~rd_s;

  sarc_seq #(.DW(DW), .STEP_CYC(STEP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_ni), .cvt_req(cvt_req), .cmp_in(cmp_in),
    .busy(busy), .start(start), .res_we(res_we), .res_ob(res_ob),
    .dac_code(dac_code)
  );

  sarc_bus #(.DW(DW), .LANE_W(LANE_W), .VALID_WIN(VALID_WIN), .POISON(POISON)) u_bus (
    .clk(clk), .rst_n(rst_ni), .start(start), .busy(busy), .res_we(res_we),
    .res_ob(res_ob), .sel_s(sel_s), .rd_s(rd_s), .lane_s(lane_s),
    .dq(dq), .dq_oe(dq_oe)
  );

  assign busy_n = ~busy;
endmodule

// File: tb/sim_sarc_top.sv
`timescale 1ns/1ps
module sim_sarc_top;
  localparam int DW = 12;
  localparam int STEP = 36;
  localparam int WIN = 300;
  localparam logic [11:0] POISON = 12'hBAD;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, sel_n, rdconv, lane_sel, cmp_in, busy_n, dq_oe;
  logic [11:0] vin, dac_code;
  logic [15:0] dq;

  assign cmp_in = (vin >= dac_code);

  sarc_top u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rdconv(rdconv), .lane_sel(lane_sel),
    .cmp_in(cmp_in), .dac_code(dac_code), .busy_n(busy_n), .dq(dq), .dq_oe(dq_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit chk_en = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // behavioural reference model, advanced on every rising edge
  logic [2:0]  m_s1, m_s2;
  logic        m_reqq, m_busy, m_req, m_st;
  int          m_step, m_bit, m_win;
  logic [11:0] m_trial, m_res;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      summary();
    end
    if (!rst_n) begin
      m_s1 = 3'b011; m_s2 = 3'b011; m_reqq = 0; m_busy = 0;
      m_step = 0; m_bit = 0; m_win = 0; m_trial = 0; m_res = 0;
    end else begin
      m_req = !m_s2[0] && !m_s2[1];
      m_st  = m_req && !m_reqq;
      if (m_busy) begin
        if (m_win < WIN) m_win++;
        if (m_st) begin
          m_busy = 0; m_trial = 0;
        end else if (m_step == STEP - 1) begin
          if (!(vin >= m_trial)) m_trial[m_bit] = 1'b0;
          m_step = 0;
          if (m_bit == 0) begin
            m_res = m_trial ^ 12'h800; m_busy = 0; m_trial = 0;
          end else begin
            m_bit--; m_trial[m_bit] = 1'b1;
          end
        end else m_step++;
      end else if (m_st) begin
        m_busy = 1; m_step = 0; m_bit = DW - 1; m_trial = 12'h800; m_win = 0;
      end
      m_reqq = m_req;
      m_s2 = m_s1;
      m_s1 = {lane_sel, rdconv, sel_n};
    end
  end

  // per-cycle comparison against the model
  logic        e_oe;
  logic [11:0] e_rv;
  logic [15:0] e_dq;
  always @(negedge clk) begin
    if (chk_en) begin
      e_oe = !m_s2[0] && m_s2[1];
      e_rv = (m_busy && m_win >= WIN) ? POISON : m_res;
      if (!e_oe) e_dq = 16'h0;
      else if (m_s2[2]) e_dq = {e_rv[3:0], 4'h0, e_rv[11:4]};
      else e_dq = {e_rv, 4'h0};
      chk("R2", {31'd0, busy_n}, {31'd0, !m_busy}, "busy_n vs model");
      chk("R3", {20'd0, dac_code}, {20'd0, m_trial}, "dac_code vs model");
      chk("R6", {31'd0, dq_oe}, {31'd0, e_oe}, "dq_oe vs model");
      chk("R7", {16'd0, dq}, {16'd0, e_dq}, "dq vs model");
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_busy(input logic lvl, input string tag);
    int k = 0;
    while (busy_n !== lvl && k < 2000) begin
      @(negedge clk);
      k++;
    end
    chk(tag, {31'd0, busy_n}, {31'd0, lvl}, "busy_n reached level");
  endtask

  // cs_last: rdconv falls first and sel_n completes the start
  task automatic conv_start(input bit cs_last);
    if (cs_last) begin
      rdconv = 1'b0; idle(3); sel_n = 1'b0;
    end else begin
      sel_n = 1'b0; idle(3); rdconv = 1'b0;
    end
    idle(2);
    rdconv = 1'b1;
  endtask

  task automatic read_chk(input bit lane, input logic [11:0] exp, input string tag);
    lane_sel = lane; sel_n = 1'b0; rdconv = 1'b1;
    idle(3);
    chk(tag, {31'd0, dq_oe}, 32'd1, "port enabled for read");
    if (!lane) chk(tag, {16'd0, dq}, {16'd0, exp, 4'h0}, "full-word lane layout");
    else       chk(tag, {16'd0, dq}, {16'd0, exp[3:0], 4'h0, exp[11:4]}, "swapped lane layout");
  endtask

  task automatic full_conv(input logic [11:0] v, input bit cs_last, input logic [11:0] exp, input string tag);
    vin = v; lane_sel = 1'b0;
    conv_start(cs_last);
    wait_busy(1'b0, "R2");
    wait_busy(1'b1, "R3");
    // R9: new result visible in the cycle busy_n rises
    chk("R9", {20'd0, dq[15:4]}, {20'd0, exp}, "result on busy rise");
    read_chk(1'b0, exp, tag);
  endtask

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; rdconv = 1'b1; lane_sel = 1'b0; vin = 12'h0;
    idle(5);
    // R1: reset state
    chk("R1", {31'd0, busy_n}, 32'd1, "busy_n in reset");
    chk("R1", {31'd0, dq_oe}, 32'd0, "dq_oe in reset");
    chk("R1", {16'd0, dq}, 32'd0, "dq in reset");
    chk("R1", {20'd0, dac_code}, 32'd0, "dac_code in reset");
    rst_n = 1'b1;
    idle(4);
    chk_en = 1'b1;
    read_chk(1'b0, 12'h000, "R1");
    sel_n = 1'b1; idle(3);

    // R4: coding at the range ends and around midscale
    full_conv(12'hFFF, 1'b1, 12'h7FF, "R4");
    full_conv(12'h800, 1'b0, 12'h000, "R4");
    full_conv(12'h7FF, 1'b1, 12'hFFF, "R4");
    read_chk(1'b1, 12'hFFF, "R7");
    full_conv(12'h000, 1'b0, 12'h800, "R4");
    full_conv(12'h5A3, 1'b1, 12'hDA3, "R3");
    read_chk(1'b1, 12'hDA3, "R7");

    // R2: rdconv activity with sel_n high starts nothing
    sel_n = 1'b1; lane_sel = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rdconv = 1'b0; idle(3); rdconv = 1'b1; idle(3);
      chk("R2", {31'd0, busy_n}, 32'd1, "no start with sel_n high");
      chk("R6", {31'd0, dq_oe}, 32'd0, "port released with sel_n high");
      chk("R6", {16'd0, dq}, 32'd0, "dq zero when released");
    end
    read_chk(1'b0, 12'hDA3, "R2");

    // R8: previous result inside the window, poison after it
    vin = 12'h123; lane_sel = 1'b0;
    conv_start(1'b0);
    wait_busy(1'b0, "R2");
    idle(100);
    chk("R8", {20'd0, dq[15:4]}, 32'hDA3, "previous result inside window");
    idle(220);
    chk("R8", {20'd0, dq[15:4]}, {20'd0, POISON}, "poison after window");
    wait_busy(1'b1, "R3");
    chk("R9", {20'd0, dq[15:4]}, 32'h923, "result on busy rise");

    // R5: abort mid-conversion keeps the stored result
    vin = 12'h456;
    conv_start(1'b1);
    wait_busy(1'b0, "R2");
    idle(50);
    rdconv = 1'b0;
    idle(4);
    chk("R5", {31'd0, busy_n}, 32'd1, "busy_n high after abort");
    chk("R5", {20'd0, dac_code}, 32'd0, "dac_code cleared after abort");
    idle(6);
    chk("R5", {31'd0, busy_n}, 32'd1, "no restart while held low");
    rdconv = 1'b1;
    read_chk(1'b0, 12'h923, "R5");
    sel_n = 1'b1; idle(3);
    full_conv(12'h456, 1'b0, 12'hC56, "R5");

    sel_n = 1'b1; rdconv = 1'b1;
    idle(5);
    summary();
  end
endmodule